// File: doc/BRIEF.md
# Clock Distributor Serial Configuration Sequencer

This block programs an external clock-distribution device over its four-wire serial control port. A pulse on `start` makes it bring the device out of power-down, pulse the device's sync pin, and then write nine 28-bit register values in ascending register order. The values come from one of two profiles held as parameters: a primary profile for the internal reference and a secondary profile for the external reference. `profile_sel` picks the profile and is sampled together with `verify_en` when the start is accepted.

When read-back is enabled, every register is read back after the writes. For each register the block sends a read-command frame and then an all-zero frame, and it samples `miso` during the second frame. The block drops the low address nibble of the returned frame and compares the remaining 28 bits with the profile entry. `done` pulses once at the end. `verify_ok` then reports whether all nine read-back words matched.

The serial clock idles low. Each frame is 32 bits long and is sent least significant bit first, and chip select stays low for the whole frame. The power-up wait, the serial clock half-period and both profile tables are parameters.

Top module: `clkdist_cfg_seq`

## Requirements
- R1: After reset, busy, done, verify_ok, sclk and mosi are 0, and cs_n, pd_n and sync_n are 1.
- R2: After an accepted start, pd_n is low for exactly WAIT_CYC cycles. Then WAIT_CYC cycles pass before sync_n falls, sync_n stays low for exactly WAIT_CYC cycles, and at least WAIT_CYC cycles pass before cs_n first falls. cs_n stays high while pd_n or sync_n is low.
- R3: cs_n stays low for a whole frame, and each frame has exactly 32 rising sclk edges. sclk is low whenever cs_n is high.
- R4: mosi changes only while sclk is low. Frame bit 0 is sent first and bit 31 last.
- R5: A write frame is {value[27:0], index[3:0]}. The nine writes use indices 0 to 8 in ascending order.
- R6: profile_sel = 0 selects the primary table and profile_sel = 1 selects the secondary table. Entry i of a table occupies bits [28*i +: 28] of that table parameter.
- R7: With verify_en = 1, the writes are followed by nine read pairs, for index 0 to 8 in ascending order. Each pair is a command frame {24'h0, index[3:0], 4'hE} followed by an all-zero frame.
- R8: During the second frame of a read pair, miso is sampled on each sclk rising edge. The first sample becomes bit 0 of the received frame, and the received bits [31:4] are the value that is compared.
- R9: After done, verify_ok is 1 only if read-back ran and all nine received values equal the selected profile entries. verify_ok is cleared when a start is accepted.
- R10: busy is 1 from the cycle after an accepted start. done is a one-cycle pulse, and busy is 0 in the cycle in which done is 1.
- R11: A start that arrives while busy is 1 is ignored. The frame stream and the result are those of the first request.
- R12: With verify_en = 0, exactly nine frames are sent and verify_ok stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load request pulse |
| profile_sel | input | 1 | 0 = primary profile, 1 = secondary profile |
| verify_en | input | 1 | Enable read-back check after the writes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of the sequence |
| verify_ok | output | 1 | All read-back values matched |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| pd_n | output | 1 | Active-low power-down to the device |
| sync_n | output | 1 | Active-low sync to the device |

## Verification
The bench builds the block with WAIT_CYC = 20 and SCLK_HALF = 2. With these values a full read-back run of 27 frames takes a few thousand cycles, so the power-up timing can be measured exactly. Both profiles, runs with and without read-back, a corrupted read-back word at the last index and a start issued mid-run all fit in one short run. The tables the bench passes in hold a distinct value in every entry, so an ordering or indexing error changes the frame stream that a device model on the pins captures.

// File: rtl/clkdist_cfg_pkg.sv
// Shared constants and state types for the clock distributor configuration
// sequencer. Assumes a device with nine 28-bit registers and a 4-bit address.
package clkdist_cfg_pkg;
    localparam int NUM_REGS  = 9;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 28;
    localparam int FRAME_W   = ADDR_W + DATA_W;
    localparam int ADDR_SLOTS = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] RD_CODE = 4'hE;

    typedef enum logic [2:0] {
        Q_IDLE, Q_PD_LO, Q_PD_HI, Q_SY_LO, Q_SY_HI, Q_WRITE, Q_RD_CMD, Q_RD_DAT
    } seq_state_t;

    typedef enum logic [1:0] {
        L_IDLE, L_SHIFT, L_TAIL, L_GAP
    } link_state_t;
endpackage

// File: rtl/clkdist_profile_mux.sv
// Profile table lookup: unpacks both parameter tables into address-indexed
// arrays and returns the entry for the requested index. Indices beyond the
// register count read as zero. Purely combinational.
module clkdist_profile_mux
    import clkdist_cfg_pkg::*;
#(
    parameter logic [NUM_REGS*DATA_W-1:0] PRI_TABLE = '0,
    parameter logic [NUM_REGS*DATA_W-1:0] SEC_TABLE = '0
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] idx,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] pri_arr [ADDR_SLOTS];
    logic [DATA_W-1:0] sec_arr [ADDR_SLOTS];

    // Unpack each table slot, padding unused addresses with zero.
    for (genvar g = 0; g < ADDR_SLOTS; g++) begin : g_slot
        if (g < NUM_REGS) begin : g_used
            assign pri_arr[g] = PRI_TABLE[g*DATA_W +: DATA_W];
            assign sec_arr[g] = SEC_TABLE[g*DATA_W +: DATA_W];
        end else begin : g_pad
            assign pri_arr[g] = '0;
            assign sec_arr[g] = '0;
        end
    end

    // Select the profile entry.
    always_comb word = sel ? sec_arr[idx] : pri_arr[idx];
endmodule

// File: rtl/clkdist_spi_link.sv
// Serial frame engine: sends one 32-bit frame LSB first with cs_n low
// throughout, sclk idling low, mosi changing on falling edges and miso
// captured on rising edges (first bit into bit 0). After the frame it keeps
// sclk low for a half period, raises cs_n, holds it for a half period and
// then pulses fin. Assumes go only arrives while the engine is idle.
module clkdist_spi_link
    import clkdist_cfg_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] tx_frame,
    input  logic               miso,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    output logic [FRAME_W-1:0] rx_frame,
    output logic               fin
);
    localparam int DIV_W = $clog2(HALF_CYC + 1);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_CYC - 1);
    localparam logic [BIT_W-1:0] BIT_END = BIT_W'(FRAME_W - 1);

    link_state_t        st;
    logic [DIV_W-1:0]   div;
    logic [BIT_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] shreg;
    logic               tick;

    // Half-period boundary of the serial clock.
    always_comb tick = (div == DIV_END);

    // Frame state machine, serial clock generation, shift out and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= L_IDLE; div <= '0; bit_idx <= '0; shreg <= '0;
            sclk <= 1'b0; cs_n <= 1'b1; mosi <= 1'b0; rx_frame <= '0; fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st)
                L_IDLE: if (go) begin
                    st <= L_SHIFT; cs_n <= 1'b0; sclk <= 1'b0; div <= '0;
                    shreg <= tx_frame; mosi <= tx_frame[0]; bit_idx <= '0;
                end
                L_SHIFT: begin
                    div <= tick ? '0 : div + 1'b1;
                    if (tick) begin
                        if (!sclk) begin
                            sclk <= 1'b1;
                            rx_frame <= {miso, rx_frame[FRAME_W-1:1]};
                        end else begin
                            sclk  <= 1'b0;
                            shreg <= shreg >> 1;
                            if (bit_idx == BIT_END) begin
                                st   <= L_TAIL;
                                mosi <= 1'b0;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                                mosi    <= shreg[1];
                            end
                        end
                    end
                end
                L_TAIL: begin
                    div <= tick ? '0 : div + 1'b1;
                    if (tick) begin cs_n <= 1'b1; st <= L_GAP; end
                end
                default: begin
                    div <= tick ? '0 : div + 1'b1;
                    if (tick) begin fin <= 1'b1; st <= L_IDLE; end
                end
            endcase
        end
    end

    // R3
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R4
    data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/clkdist_seq_ctrl.sv
// Sequence controller: on an accepted start it latches the profile and
// read-back choice, runs the power-down release and sync pulse with
// WAIT_CYC-cycle steps, then issues the nine write frames and, optionally,
// nine read pairs, checking each returned value. Assumes the frame engine
// answers each go with exactly one fin.
module clkdist_seq_ctrl
    import clkdist_cfg_pkg::*;
#(
    parameter int WAIT_CYC = 14000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               profile_sel,
    input  logic               verify_en,
    input  logic               fin,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic [DATA_W-1:0]  ref_word,
    output logic               go,
    output logic [FRAME_W-1:0] tx_frame,
    output logic [ADDR_W-1:0]  reg_idx,
    output logic               prof_q,
    output logic               busy,
    output logic               done,
    output logic               verify_ok,
    output logic               pd_n,
    output logic               sync_n
);
    localparam int WT_W = $clog2(WAIT_CYC + 1);
    localparam logic [WT_W-1:0]   WAIT_END = WT_W'(WAIT_CYC - 1);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

    seq_state_t      st;
    logic [WT_W-1:0] cnt;
    logic            ver_q;
    logic            all_ok;
    logic            wait_end;
    logic            rd_bad;
    logic            last_idx;

    // Step timer terminal, last register and read mismatch for this frame.
    always_comb begin
        wait_end = (cnt == WAIT_END);
        last_idx = (reg_idx == LAST_IDX);
        rd_bad   = (st == Q_RD_DAT) && fin && (rx_data != ref_word);
    end

    // Frame content for the current step.
    always_comb begin
        case (st)
            Q_RD_CMD: tx_frame = {{(FRAME_W-2*ADDR_W){1'b0}}, reg_idx, RD_CODE};
            Q_RD_DAT: tx_frame = '0;
            default:  tx_frame = {ref_word, reg_idx};
        endcase
    end

    // Busy whenever the sequence is not idle.
    always_comb busy = (st != Q_IDLE);

    // Main sequence: power-up steps, write frames, read pairs, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= Q_IDLE; cnt <= '0; reg_idx <= '0; prof_q <= 1'b0; ver_q <= 1'b0;
            all_ok <= 1'b0; go <= 1'b0; done <= 1'b0; verify_ok <= 1'b0;
            pd_n <= 1'b1; sync_n <= 1'b1;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            case (st)
                Q_IDLE: if (start) begin
                    st <= Q_PD_LO; pd_n <= 1'b0; cnt <= '0;
                    prof_q <= profile_sel; ver_q <= verify_en;
                    all_ok <= 1'b1; verify_ok <= 1'b0;
                end
                Q_PD_LO: begin
                    cnt <= wait_end ? '0 : cnt + 1'b1;
                    if (wait_end) begin pd_n <= 1'b1; st <= Q_PD_HI; end
                end
                Q_PD_HI: begin
                    cnt <= wait_end ? '0 : cnt + 1'b1;
                    if (wait_end) begin sync_n <= 1'b0; st <= Q_SY_LO; end
                end
                Q_SY_LO: begin
                    cnt <= wait_end ? '0 : cnt + 1'b1;
                    if (wait_end) begin sync_n <= 1'b1; st <= Q_SY_HI; end
                end
                Q_SY_HI: begin
                    cnt <= wait_end ? '0 : cnt + 1'b1;
                    if (wait_end) begin st <= Q_WRITE; reg_idx <= '0; go <= 1'b1; end
                end
                Q_WRITE: if (fin) begin
                    if (!last_idx) begin
                        reg_idx <= reg_idx + 1'b1; go <= 1'b1;
                    end else if (ver_q) begin
                        st <= Q_RD_CMD; reg_idx <= '0; go <= 1'b1;
                    end else begin
                        st <= Q_IDLE; done <= 1'b1;
                    end
                end
                Q_RD_CMD: if (fin) begin st <= Q_RD_DAT; go <= 1'b1; end
                default: if (fin) begin
                    if (rd_bad) all_ok <= 1'b0;
                    if (!last_idx) begin
                        reg_idx <= reg_idx + 1'b1; st <= Q_RD_CMD; go <= 1'b1;
                    end else begin
                        st <= Q_IDLE; done <= 1'b1;
                        verify_ok <= all_ok & ~rd_bad;
                    end
                end
            endcase
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    ok_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(verify_ok) |-> done);
    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (reg_idx <= LAST_IDX));
endmodule

// File: rtl/clkdist_cfg_seq.sv
// Top of the clock distributor configuration sequencer: joins the sequence
// controller, the profile table lookup and the serial frame engine. Assumes
// miso is synchronous to clk (the device answers on sclk edges made here).
module clkdist_cfg_seq
    import clkdist_cfg_pkg::*;
#(
    parameter int WAIT_CYC  = 14000,
    parameter int SCLK_HALF = 4,
    parameter logic [NUM_REGS*DATA_W-1:0] PRI_TABLE = {
        28'h0000180, 28'h1400000, 28'h1001000, 28'h00009D4, 28'h1540000,
        28'h1540000, 28'h1540000, 28'h1540000, 28'h1540000},
    parameter logic [NUM_REGS*DATA_W-1:0] SEC_TABLE = {
        28'h0000180, 28'h1400000, 28'h1001000, 28'h000019B, 28'h1540020,
        28'h1540020, 28'h1540020, 28'h1540020, 28'h1540020}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic profile_sel,
    input  logic verify_en,
    output logic busy,
    output logic done,
    output logic verify_ok,
    output logic sclk,
    output logic cs_n,
    output logic mosi,
    input  logic miso,
    output logic pd_n,
    output logic sync_n
);
    logic               go;
    logic               fin;
    logic [FRAME_W-1:0] tx_frame;
    logic [FRAME_W-1:0] rx_frame;
    logic [ADDR_W-1:0]  reg_idx;
    logic [DATA_W-1:0]  ref_word;
    logic               prof_q;

    clkdist_seq_ctrl #(.WAIT_CYC(WAIT_CYC)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .profile_sel(profile_sel),
        .verify_en(verify_en), .fin(fin), .rx_data(rx_frame[FRAME_W-1:ADDR_W]),
        .ref_word(ref_word), .go(go), .tx_frame(tx_frame), .reg_idx(reg_idx),
        .prof_q(prof_q), .busy(busy), .done(done), .verify_ok(verify_ok),
        .pd_n(pd_n), .sync_n(sync_n)
    );

    clkdist_profile_mux #(.PRI_TABLE(PRI_TABLE), .SEC_TABLE(SEC_TABLE)) i_prof (
        .sel(prof_q), .idx(reg_idx), .word(ref_word)
    );

    clkdist_spi_link #(.HALF_CYC(SCLK_HALF)) i_link (
        .clk(clk), .rst_n(rst_n), .go(go), .tx_frame(tx_frame), .miso(miso),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .rx_frame(rx_frame), .fin(fin)
    );

    // R2
    pwr_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_n || !sync_n) |-> cs_n);
endmodule

// File: tb/test_clkdist_cfg_seq.sv
module test_clkdist_cfg_seq;
    localparam int WAITC = 20;
    localparam int HALF  = 2;
    localparam logic [9*28-1:0] TB_PRI = {
        28'h1400188, 28'h1400077, 28'h1001066, 28'h00009D5, 28'h1540044,
        28'h1540033, 28'h1540022, 28'h1540011, 28'h1540000};
    localparam logic [9*28-1:0] TB_SEC = {
        28'h0A00180, 28'h0B00170, 28'h0C01060, 28'h000019B, 28'h2540420,
        28'h2540320, 28'h2540220, 28'h2540120, 28'h2540020};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, profile_sel = 1'b0, verify_en = 1'b0;
    logic busy, done, verify_ok, sclk, cs_n, mosi, miso, pd_n, sync_n;

    clkdist_cfg_seq #(.WAIT_CYC(WAITC), .SCLK_HALF(HALF),
                      .PRI_TABLE(TB_PRI), .SEC_TABLE(TB_SEC)) i_clkdist_cfg_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .profile_sel(profile_sel),
        .verify_en(verify_en), .busy(busy), .done(done), .verify_ok(verify_ok),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .pd_n(pd_n), .sync_n(sync_n)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [27:0] tbl(input bit p, input int i);
        return p ? TB_SEC[i*28 +: 28] : TB_PRI[i*28 +: 28];
    endfunction

    function automatic logic [31:0] exp_frame(input bit p, input int k);
        int j;
        if (k < 9) return {tbl(p, k), 4'(k)};
        j = (k - 9) / 2;
        if (((k - 9) % 2) == 0) return {24'h0, 4'(j), 4'hE};
        return 32'h0;
    endfunction

    // Device model on the serial pins.
    logic [27:0] dev_regs [16];
    logic [31:0] cur, rd_frame;
    int bcnt = 0, corrupt_idx = -1;
    bit rd_pend = 0, rd_phase = 0;
    logic [3:0] rd_idx = 4'h0;
    logic [31:0] obs_q[$];
    int obs_b[$];

    always @(negedge cs_n) begin
        bcnt = 0; cur = '0; rd_phase = rd_pend; rd_pend = 0;
        rd_frame = {dev_regs[rd_idx] ^ ((int'(rd_idx) == corrupt_idx) ? 28'h1 : 28'h0), 4'hA};
    end
    always @(posedge sclk) if (!cs_n) begin
        if (bcnt < 32) cur[bcnt] = mosi;
        bcnt++;
    end
    always @(posedge cs_n) if (rst_n === 1'b1) begin
        obs_q.push_back(cur); obs_b.push_back(bcnt);
        if (!rd_phase) begin
            if (cur[3:0] == 4'hE) begin rd_pend = 1; rd_idx = cur[7:4]; end
            else dev_regs[cur[3:0]] = cur[31:4];
        end
        rd_phase = 0;
    end
    assign miso = (rd_phase && !cs_n && bcnt < 32) ? rd_frame[bcnt] : 1'b0;

    // Behavioural model of busy, updated at each edge from pre-edge inputs.
    bit model_busy = 0, prev_done = 0, prev_pd = 1, prev_sy = 1, prev_cs = 1;
    int t_pd_fall, t_pd_rise, t_sy_fall, t_sy_rise, t_cs_fall;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) model_busy = 0;
        else if (!model_busy && start) model_busy = 1;
    end

    // Per-clock comparison against the model and pin invariants.
    always @(negedge clk) if (rst_n) begin
        if (done) model_busy = 0;
        chk(busy == model_busy, "R10 busy vs model", busy, model_busy);
        chk(!(cs_n && sclk), "R3 sclk low while cs_n high", sclk, 0);
        chk(!((!pd_n || !sync_n) && !cs_n), "R2 cs_n high during power-up", cs_n, 1);
        chk(!(done && prev_done), "R10 done single cycle", done, 0);
        if (prev_pd && !pd_n) t_pd_fall = cyc;
        if (!prev_pd && pd_n) t_pd_rise = cyc;
        if (prev_sy && !sync_n) t_sy_fall = cyc;
        if (!prev_sy && sync_n) t_sy_rise = cyc;
        if (prev_cs && !cs_n && t_cs_fall < 0) t_cs_fall = cyc;
        prev_done = done; prev_pd = pd_n; prev_sy = sync_n; prev_cs = cs_n;
    end

    task automatic run_seq(input bit p, input bit v, input int cor, input bit poke,
                           input bit exp_ok, input string tag);
        int n;
        obs_q.delete(); obs_b.delete();
        corrupt_idx = cor;
        t_pd_fall = -1; t_pd_rise = -1; t_sy_fall = -1; t_sy_rise = -1; t_cs_fall = -1;
        @(negedge clk); start = 1; profile_sel = p; verify_en = v;
        @(negedge clk); start = 0; profile_sel = ~p; verify_en = ~v;
        chk(busy == 1, {"R10 busy after start ", tag}, busy, 1);
        chk(verify_ok == 0, {"R9 cleared at start ", tag}, verify_ok, 0);
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1;
            @(negedge clk); start = 0;
        end
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(done == 1, {"R10 done reached ", tag}, done, 1);
        chk(verify_ok == exp_ok, {"R9 verify_ok ", tag}, verify_ok, exp_ok);
        chk(t_pd_rise - t_pd_fall == WAITC, {"R2 pd_n low width ", tag}, t_pd_rise - t_pd_fall, WAITC);
        chk(t_sy_fall - t_pd_rise == WAITC, {"R2 pd_n to sync_n ", tag}, t_sy_fall - t_pd_rise, WAITC);
        chk(t_sy_rise - t_sy_fall == WAITC, {"R2 sync_n low width ", tag}, t_sy_rise - t_sy_fall, WAITC);
        chk(t_cs_fall - t_sy_rise >= WAITC, {"R2 sync_n to first frame ", tag}, t_cs_fall - t_sy_rise, WAITC);
        @(negedge clk);
        chk(busy == 0 && done == 0, {"R10 idle after done ", tag}, busy, 0);
        // R7 R12 frame count
        chk(obs_q.size() == (v ? 27 : 9), {"R7 R12 frame count ", tag}, obs_q.size(), v ? 27 : 9);
        for (int k = 0; k < obs_q.size() && k < 27; k++) begin
            // R4 R5 R6 R7: frame contents and order
            chk(obs_q[k] == exp_frame(p, k), $sformatf("R5 R6 R7 frame %0d %s", k, tag),
                obs_q[k], exp_frame(p, k));
            chk(obs_b[k] == 32, $sformatf("R3 bit count frame %0d %s", k, tag), obs_b[k], 32);
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) dev_regs[i] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(verify_ok == 0, "R1 verify_ok", verify_ok, 0);
        chk(cs_n == 1 && sclk == 0 && mosi == 0, "R1 serial pins", {cs_n, sclk, mosi}, 3'b100);
        chk(pd_n == 1 && sync_n == 1, "R1 pd_n sync_n", {pd_n, sync_n}, 2'b11);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R6 R7 R8 R9: primary with read-back, all match
        run_seq(1'b0, 1'b1, -1, 1'b0, 1'b1, "primary verify");
        // R6 R9: secondary with read-back
        run_seq(1'b1, 1'b1, -1, 1'b0, 1'b1, "secondary verify");
        // R12: no read-back
        run_seq(1'b1, 1'b0, -1, 1'b0, 1'b0, "secondary write only");
        // R8 R9: mismatch at the last index
        run_seq(1'b0, 1'b1, 8, 1'b0, 1'b0, "corrupt last");
        // R9: mismatch at the first index
        run_seq(1'b1, 1'b1, 0, 1'b0, 1'b0, "corrupt first");
        // R11: second start while busy is ignored
        run_seq(1'b0, 1'b1, -1, 1'b1, 1'b1, "start while busy");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule